// File: doc/BRIEF.md
# Electronic Dice Roller

This block turns a roll button and a slow tick strobe into a dice result shown on a seven-segment digit. While a roll is active, every clock cycle in which the tick strobe is high advances a decimal count by one. The count restarts at zero whenever it would reach seven, so it cycles through 0 to 6.

A roll is active while the button is held. It then stays active for a fixed number of further ticks after the button is let go, which mimics a run that slowly dies out. When the run ends the count stops and is held as the result, and a one-clock completion pulse is raised. A result of 0 means the player rolls again; that is left to the surrounding logic.

The restart at seven is not a numeric compare. It is taken from a rising edge of segment b of the decoded next value. Segment b is off for 5 and 6 and on again for 7, so the count register steps from 6 straight to 0 on the same tick.

Top module: `dice_roller`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `count` to 0, `seg` to 7'h3F and `roll_done` to 0, and cancels any active run.
- R2: While a roll is active, each clock edge with `tick_en` high adds one to `count`, and each edge with `tick_en` low leaves `count` unchanged.
- R3: `count` never holds a value above 6. A counted tick taken at 6 gives 0 on that same edge.
- R4: `seg` changes on the same edge as `count` and shows its digit with bit 0 = a through bit 6 = g, high = lit. The codes are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D (hex).
- R5: After `roll_btn` falls, exactly HOLD_TICKS further ticks are counted, and then the run ends.
- R6: A `roll_btn` press during the post-release run reloads the run time, so HOLD_TICKS ticks are counted after the new release.
- R7: `roll_done` is high for exactly one clock cycle, beginning one clock edge after the edge that applied the last counted tick of a run.
- R8: With no roll active, ticks leave `count` and `seg` unchanged, so the result is held.
- R9: A reset applied during a run ends it without any `roll_done` pulse.
- R10: Starting from 0, the held result after a run of N counted ticks equals N mod 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| roll_btn | input | 1 | Roll button, high while pressed |
| tick_en | input | 1 | Count tick strobe, one clock wide per tick |
| seg | output | 7 | Segment lines a..g on bits 0..6, high = lit |
| count | output | 4 | Current dice value |
| roll_done | output | 1 | One-clock pulse when a run ends |

## Verification
The counter is first driven with a tick on every cycle, then with sparse and gapped ticks. This separates counting by tick from counting by clock, and it carries the value through several 6-to-0 restarts while the segment code is compared at each step. Release runs with and without a mid-run press tell a fixed run length apart from a reloaded one. Ticks after the end show whether the result is held. Rolls of 16, 17, 21 and 28 total ticks, including ones that land on 0, test the modulo-7 result, and a reset taken mid-run confirms that no completion pulse follows.

// File: rtl/dice_pkg.sv
package dice_pkg;

  localparam int SEG_W    = 7;
  localparam int SEG_B    = 1;
  localparam int DIGIT_HI = 9;

  typedef logic [SEG_W-1:0] seg_t;

  // Decimal digit to segment pattern, bit 0 = a .. bit 6 = g, high = lit.
  function automatic seg_t digit_to_seg(input logic [3:0] d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/roll_timer.sv
module roll_timer #(
  parameter int HOLD_TICKS = 16,
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic roll_btn,
  input  logic tick_en,
  output logic run_active,
  output logic run_end
);

  logic [HOLD_W-1:0] hold_q;
  logic              active_d1;

  assign run_active = roll_btn || (hold_q != '0);

  // Post-release hold-off, reloaded on every cycle the button is held.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (roll_btn) begin
      hold_q <= HOLD_W'(HOLD_TICKS);
    end else if (tick_en && (hold_q != '0)) begin
      hold_q <= hold_q - HOLD_W'(1);
    end
  end

  // Falling edge of the run gives a registered one-clock pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      active_d1 <= 1'b0;
      run_end   <= 1'b0;
    end else begin
      active_d1 <= run_active;
      run_end   <= active_d1 && !run_active;
    end
  end

endmodule

// File: rtl/dice_counter.sv
module dice_counter
  import dice_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_nxt
);

  logic [CNT_W-1:0] inc;
  seg_t             inc_seg;
  seg_t             nxt_seg;
  logic             b_prev_q;
  logic             b_rise;

  always_comb begin
    inc     = count_q + CNT_W'(1);
    inc_seg = digit_to_seg(4'(inc));
    // Segment b going from dark to lit marks entry into seven.
    b_rise  = advance && !b_prev_q && inc_seg[SEG_B];
    if (!advance) begin
      count_nxt = count_q;
    end else if (b_rise || (int'(inc) > DIGIT_HI)) begin
      count_nxt = '0;
    end else begin
      count_nxt = inc;
    end
    nxt_seg = digit_to_seg(4'(count_nxt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      b_prev_q <= 1'b1;
    end else begin
      count_q  <= count_nxt;
      b_prev_q <= nxt_seg[SEG_B];
    end
  end

endmodule

// File: rtl/seg_driver.sv
module seg_driver
  import dice_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] digit_nxt,
  output seg_t             seg_q
);

  seg_t pattern;
  seg_t rst_pattern;

  assign pattern     = digit_to_seg(4'(digit_nxt));
  assign rst_pattern = digit_to_seg(4'd0);

  for (genvar i = 0; i < SEG_W; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) seg_q[i] <= rst_pattern[i];
      else     seg_q[i] <= pattern[i];
    end
  end

endmodule

// File: rtl/dice_roller.sv
module dice_roller
  import dice_pkg::*;
#(
  parameter int HOLD_TICKS = 16,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             roll_btn,
  input  logic             tick_en,
  output logic [6:0]       seg,
  output logic [CNT_W-1:0] count,
  output logic             roll_done
);

  logic             run_active;
  logic             advance;
  logic [CNT_W-1:0] count_nxt;

  roll_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .roll_btn   (roll_btn),
    .tick_en    (tick_en),
    .run_active (run_active),
    .run_end    (roll_done)
  );

  assign advance = run_active && tick_en;

  dice_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .count_q   (count),
    .count_nxt (count_nxt)
  );

  seg_driver #(.CNT_W(CNT_W)) u_seg (
    .clk       (clk),
    .rst       (rst),
    .digit_nxt (count_nxt),
    .seg_q     (seg)
  );

endmodule

// File: rtl/dice_roller_chk.sv
module dice_roller_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             run_active,
  input logic [6:0]       seg,
  input logic [CNT_W-1:0] count,
  input logic             roll_done
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count == '0) && (seg == 7'h3F) && !roll_done);

  // R2
  idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(count));

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= 6);

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run_active && tick_en && (int'(count) == 6)) |=> (count == '0));

  // R4
  seg_b_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(count) >= 5) |-> !seg[1]);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    roll_done |=> !roll_done);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !run_active |=> $stable(count) && $stable(seg));

endmodule

bind dice_roller dice_roller_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_en    (tick_en),
  .run_active (run_active),
  .seg        (seg),
  .count      (count),
  .roll_done  (roll_done)
);

// File: tb/dice_roller_test.sv
module dice_roller_test;

  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       roll_btn = 1'b0;
  logic       tick_en = 1'b0;
  logic [6:0] seg;
  logic [3:0] count;
  logic       roll_done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dice_roller #(.HOLD_TICKS(HOLD), .CNT_W(4)) uut (
    .clk       (clk),
    .rst       (rst),
    .roll_btn  (roll_btn),
    .tick_en   (tick_en),
    .seg       (seg),
    .count     (count),
    .roll_done (roll_done)
  );

  function automatic logic [6:0] exp_seg(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  // One clock: apply tick, return just after the edge.
  task automatic cyc(input logic t);
    tick_en = t;
    @(posedge clk);
    #1;
    tick_en = 1'b0;
  endtask

  task automatic do_reset;
    rst = 1'b1; roll_btn = 1'b0;
    cyc(1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 count", count, 0);
    check("R1 seg", seg, 7'h3F);
    check("R1 roll_done", roll_done, 0);
  endtask

  task automatic t_count_held;
    int exp = 0;
    do_reset();
    roll_btn = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1);
      exp = (exp + 1) % 7;
      check("R2 R3 count step", count, exp);
      check("R4 seg", seg, exp_seg(exp));
    end
    for (int i = 0; i < 18; i++) begin
      logic t = (i % 3 == 0);
      cyc(t);
      if (t) exp = (exp + 1) % 7;
      check("R2 gapped ticks", count, exp);
    end
    roll_btn = 1'b0;
  endtask

  task automatic t_release;
    int exp;
    do_reset();
    roll_btn = 1'b1;
    cyc(1'b1);
    roll_btn = 1'b0;
    exp = 1;
    for (int i = 0; i < HOLD; i++) begin
      cyc(1'b0);
      cyc(1'b1);
      exp = (exp + 1) % 7;
      check("R5 post-release tick", count, exp);
    end
    cyc(1'b1);
    check("R7 roll_done high", roll_done, 1);
    check("R5 run ended", count, exp);
    cyc(1'b1);
    check("R7 roll_done single", roll_done, 0);
    for (int i = 0; i < 10; i++) cyc(1'b1);
    check("R8 held count", count, exp);
    check("R8 held seg", seg, exp_seg(exp));
  endtask

  task automatic t_extend;
    int exp;
    do_reset();
    roll_btn = 1'b1;
    cyc(1'b0);
    roll_btn = 1'b0;
    for (int i = 0; i < 10; i++) cyc(1'b1);
    roll_btn = 1'b1;
    cyc(1'b1);
    roll_btn = 1'b0;
    check("R6 roll_done before end", roll_done, 0);
    for (int i = 0; i < HOLD + 5; i++) cyc(1'b1);
    exp = (10 + 1 + HOLD) % 7;
    check("R6 extended run total", count, exp);
  endtask

  task automatic t_reset_mid;
    int saw = 0;
    do_reset();
    roll_btn = 1'b1;
    cyc(1'b1);
    roll_btn = 1'b0;
    cyc(1'b1);
    rst = 1'b1;
    cyc(1'b1);
    rst = 1'b0;
    check("R9 count after reset", count, 0);
    for (int i = 0; i < HOLD + 4; i++) begin
      cyc(1'b1);
      if (roll_done) saw = 1;
    end
    check("R9 no done pulse", saw, 0);
    check("R9 run cancelled", count, 0);
  endtask

  task automatic t_mod7(input int held_ticks);
    int total = held_ticks + HOLD;
    do_reset();
    roll_btn = 1'b1;
    if (held_ticks == 0) cyc(1'b0);
    for (int i = 0; i < held_ticks; i++) cyc(1'b1);
    roll_btn = 1'b0;
    for (int i = 0; i < HOLD + 6; i++) cyc(1'b1);
    check("R10 result mod 7", count, total % 7);
    check("R10 result seg", seg, exp_seg(total % 7));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_count_held();
    t_release();
    t_extend();
    t_reset_mid();
    t_mod7(0);
    t_mod7(1);
    t_mod7(5);
    t_mod7(12);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule